// File: doc/BRIEF.md
# Interleaved Pseudo-Carry Lookahead Adder

This block adds two unsigned binary operands and an incoming carry with no clock and no state. It is built from 8-bit slices. Inside each slice the carry work is split into two independent lookahead chains that run side by side. One chain serves the even bit positions and the other serves the odd ones. Each chain is at most four terms deep, and both start from the slice's incoming carry.

The chains do not produce true carries. They produce pseudo-carries built from merged two-bit generate and propagate terms. A pseudo-carry at bit i is true when bit i generates, or when a carry arrives into bit i. Each sum bit and the slice carry-out are then recovered with a single AND against the transmit signal of the bit below. Slices are chained through their carries, and a WIDTH parameter chooses an 8-, 16-, 32- or 64-bit adder. The block can be placed directly inside any datapath stage that needs a wide addition.

Top module: `cla_split_adder`

## Requirements
- R1: `{cout, sum}` equals `a + b + cin` as an unsigned WIDTH+1-bit result, for every operand pattern.
- R2: WIDTH is a multiple of 8 (8, 16, 32 or 64). The adder is WIDTH/8 slices, and the carry-out of slice k is the carry-in of slice k+1.
- R3: Per bit, generate is `a&b`, half-sum is `a^b` and transmit is `a|b`. Bit 0 of the sum is `a[0]^b[0]^cin`.
- R4: The even chain covers bits 0, 2, 4 and 6 of a slice. Its first pseudo-carry is `g0 | cin`, and each even pseudo-carry h_i equals `g_i | c_{i-1}`, where c_{i-1} is the true carry into bit i.
- R5: The odd chain covers bits 1, 3, 5 and 7. It is seeded by the slice carry-in through `t0`, giving `h1 = g1 | g0 | (t0 & cin)`, and each odd pseudo-carry h_i equals `g_i | c_{i-1}`.
- R6: For bit i > 0, sum bit i is `p_i ^ (t_{i-1} & h_{i-1})`. The true carry out of bit i is `t_i & h_i`.
- R7: The slice carry-out is `t7 & h7`. When every bit transmits and none generates (all half-sums 1), the carry-in passes unchanged to the top-level carry-out.
- R8: The block is purely combinational. A change on any input reaches `sum` and `cout` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First addend |
| b | input | WIDTH | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
The bound checker compares every internal pseudo-carry against a ripple reference of the true carries, on every input change. It also checks each recovered carry `t_i & h_i`, each slice-to-slice link and the full result, so a fault in one chain is caught at the bit where it occurs. Some behaviours only the bench can show: that the 8-bit variant is correct over its whole input space, and that the 16- and 32-bit variants are correct. It also shows that long all-propagate runs across slice boundaries deliver the carry-in to the top, and that outputs follow input changes without a clock.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int SLICE_W = 8;
  localparam int CHAIN_D = SLICE_W / 2;

  // Flat sum-of-products lookahead over one chain of merged terms.
  // res[k] = OR_j (gg[j] & pp[j+1..k]) | (seed & pp[0..k])
  function automatic logic [CHAIN_D-1:0] flat_lookahead(
    input logic [CHAIN_D-1:0] gg,
    input logic [CHAIN_D-1:0] pp,
    input logic               seed
  );
    logic [CHAIN_D-1:0] res;
    logic               term;
    for (int k = 0; k < CHAIN_D; k++) begin
      res[k] = 1'b0;
      for (int j = 0; j <= k; j++) begin
        term = gg[j];
        for (int m = j + 1; m <= k; m++) term = term & pp[m];
        res[k] = res[k] | term;
      end
      term = seed;
      for (int m = 0; m <= k; m++) term = term & pp[m];
      res[k] = res[k] | term;
    end
    return res;
  endfunction

  // Sum recovery from the pseudo-carry of the bit below.
  function automatic logic recover_sum(input logic half, input logic h_prev, input logic t_prev);
    return half ^ (h_prev & t_prev);
  endfunction
endpackage

// File: rtl/cla_pair_terms.sv
module cla_pair_terms #(
  parameter int W = cla_pkg::SLICE_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] hsum,
  output logic [W-1:0] xmit,
  output logic [W-1:0] grp_g,
  output logic [W-1:0] grp_p
);
  logic [W-1:0] gen;

  assign gen  = a & b;
  assign hsum = a ^ b;
  assign xmit = a | b;

  for (genvar i = 0; i < W; i++) begin : g_pair
    if (i == 0) begin : g_lsb
      assign grp_g[i] = gen[0];
      assign grp_p[i] = 1'b1;
    end else if (i == 1) begin : g_second
      assign grp_g[i] = gen[1] | gen[0];
      assign grp_p[i] = xmit[0];
    end else begin : g_upper
      assign grp_g[i] = gen[i] | gen[i-1];
      assign grp_p[i] = xmit[i-1] & xmit[i-2];
    end
  end
endmodule

// File: rtl/cla_pseudo_chain.sv
module cla_pseudo_chain #(
  parameter int DEPTH = cla_pkg::CHAIN_D
) (
  input  logic [DEPTH-1:0] grp_g,
  input  logic [DEPTH-1:0] grp_p,
  input  logic             seed,
  output logic [DEPTH-1:0] hout
);
  assign hout = cla_pkg::flat_lookahead(grp_g, grp_p, seed);
endmodule

// File: rtl/cla_sum_recover.sv
module cla_sum_recover #(
  parameter int W = cla_pkg::SLICE_W
) (
  input  logic [W-1:0] hsum,
  input  logic [W-1:0] xmit,
  input  logic [W-1:0] pcarry,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  assign sum[0] = hsum[0] ^ cin;
  for (genvar i = 1; i < W; i++) begin : g_sum
    assign sum[i] = cla_pkg::recover_sum(hsum[i], pcarry[i-1], xmit[i-1]);
  end
  assign cout = xmit[W-1] & pcarry[W-1];
endmodule

// File: rtl/cla_slice.sv
module cla_slice
  import cla_pkg::*;
(
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               cin,
  output logic [SLICE_W-1:0] sum,
  output logic               cout,
  output logic [SLICE_W-1:0] pcarry,
  output logic [SLICE_W-1:0] xmit
);
  logic [SLICE_W-1:0] hsum, grp_g, grp_p;

  cla_pair_terms #(.W(SLICE_W)) u_terms (
    .a(a), .b(b), .hsum(hsum), .xmit(xmit), .grp_g(grp_g), .grp_p(grp_p)
  );

  // parity 0: even positions, parity 1: odd positions
  for (genvar par = 0; par < 2; par++) begin : g_chain
    logic [CHAIN_D-1:0] gs, ps, hs;
    for (genvar k = 0; k < CHAIN_D; k++) begin : g_pick
      assign gs[k] = grp_g[2*k+par];
      assign ps[k] = grp_p[2*k+par];
      assign pcarry[2*k+par] = hs[k];
    end
    cla_pseudo_chain #(.DEPTH(CHAIN_D)) u_chain (
      .grp_g(gs), .grp_p(ps), .seed(cin), .hout(hs)
    );
  end

  cla_sum_recover #(.W(SLICE_W)) u_sum (
    .hsum(hsum), .xmit(xmit), .pcarry(pcarry), .cin(cin), .sum(sum), .cout(cout)
  );
endmodule

// File: rtl/cla_split_adder.sv
module cla_split_adder #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int SW     = cla_pkg::SLICE_W;
  localparam int SLICES = WIDTH / SW;

  // named internal events, observed by the bound checker
  logic [SLICES:0]  link;
  logic [WIDTH-1:0] pcarry;
  logic [WIDTH-1:0] xmit;

  assign link[0] = cin;
  assign cout    = link[SLICES];

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    cla_slice u_slice (
      .a(a[s*SW +: SW]),
      .b(b[s*SW +: SW]),
      .cin(link[s]),
      .sum(sum[s*SW +: SW]),
      .cout(link[s+1]),
      .pcarry(pcarry[s*SW +: SW]),
      .xmit(xmit[s*SW +: SW])
    );
  end
endmodule

// File: rtl/cla_split_adder_chk.sv
module cla_split_adder_chk #(
  parameter int WIDTH = 64
) (
  input logic [WIDTH-1:0]              a,
  input logic [WIDTH-1:0]              b,
  input logic                          cin,
  input logic [WIDTH-1:0]              sum,
  input logic                          cout,
  input logic [WIDTH/8:0]              link,
  input logic [WIDTH-1:0]              pcarry,
  input logic [WIDTH-1:0]              xmit
);
  localparam int SLICES = WIDTH / 8;

  logic [WIDTH-1:0] ref_c;     // true carry out of each bit
  logic [WIDTH-1:0] c_into;    // true carry into each bit
  logic             run;

  always_comb begin
    run = cin;
    for (int i = 0; i < WIDTH; i++) begin
      run = (a[i] & b[i]) | ((a[i] | b[i]) & run);
      ref_c[i] = run;
    end
  end

  if (WIDTH > 1) begin : g_into
    assign c_into = {ref_c[WIDTH-2:0], cin};
  end else begin : g_into1
    assign c_into = cin;
  end

  always_comb begin
    // R1
    sum_total_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}));
    // R3
    lsb_sum_chk: assert (sum[0] == (a[0] ^ b[0] ^ cin));
    for (int i = 0; i < WIDTH; i++) begin
      // R4 R5
      pseudo_carry_chk: assert (pcarry[i] == ((a[i] & b[i]) | c_into[i]));
      // R6
      carry_recover_chk: assert ((xmit[i] & pcarry[i]) == ref_c[i]);
    end
    for (int k = 1; k <= SLICES; k++) begin
      // R2 R7
      slice_link_chk: assert (link[k] == ref_c[8*k-1]);
    end
  end
endmodule

bind cla_split_adder cla_split_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
  .link(link), .pcarry(pcarry), .xmit(xmit)
);

// File: tb/cla_split_adder_bench.sv
module cla_split_adder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  int compared   = 0;
  int mismatched = 0;
  int unsigned cyc = 0;
  bit finished = 1'b0;

  logic [63:0] a64, b64, s64;
  logic        ci64, co64;
  logic [31:0] a32, b32, s32;
  logic        ci32, co32;
  logic [15:0] a16, b16, s16;
  logic        ci16, co16;
  logic [7:0]  a8, b8, s8;
  logic        ci8, co8;

  cla_split_adder #(.WIDTH(64)) u_cla_split_adder (.a(a64), .b(b64), .cin(ci64), .sum(s64), .cout(co64));
  cla_split_adder #(.WIDTH(32)) u_cla32 (.a(a32), .b(b32), .cin(ci32), .sum(s32), .cout(co32));
  cla_split_adder #(.WIDTH(16)) u_cla16 (.a(a16), .b(b16), .cin(ci16), .sum(s16), .cout(co16));
  cla_split_adder #(.WIDTH(8))  u_cla8  (.a(a8),  .b(b8),  .cin(ci8),  .sum(s8),  .cout(co8));

  // bit-serial reference, written independently of the design
  function automatic logic [64:0] model_add(input logic [63:0] x, input logic [63:0] y,
                                            input logic ci, input int w);
    logic [64:0] r = '0;
    logic c = ci;
    for (int i = 0; i < w; i++) begin
      r[i] = x[i] ^ y[i] ^ c;
      c = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
    end
    r[w] = c;
    return r;
  endfunction

  task automatic check(input string tag, input logic [64:0] act, input logic [64:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply64(input string tag, input logic [63:0] x, input logic [63:0] y, input logic ci);
    a64 = x; b64 = y; ci64 = ci;
    #1;
    check(tag, {co64, s64}, model_add(x, y, ci, 64));
  endtask

  always @(posedge clk) begin
    if (!rst) cyc++;
    if (cyc > 200000 && !finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected < 200000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [63:0] x, y;
    a64 = '0; b64 = '0; ci64 = 1'b0;
    a32 = '0; b32 = '0; ci32 = 1'b0;
    a16 = '0; b16 = '0; ci16 = 1'b0;
    a8  = '0; b8  = '0; ci8  = 1'b0;
    void'($urandom(32'd20240611));
    #25 rst = 1'b0;
    #3;

    // idle operands give an all-zero result
    apply64("R1 zero operands", 64'h0, 64'h0, 1'b0);
    // R3: bit 0 follows cin
    apply64("R3 cin only", 64'h0, 64'h0, 1'b1);
    apply64("R3 lsb carry", 64'h1, 64'h0, 1'b1);
    // R4: generates at even positions
    apply64("R4 even generate", 64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555, 1'b0);
    apply64("R4 even generate cin", 64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555, 1'b1);
    // R5: generates at odd positions, odd seed via t0
    apply64("R5 odd generate", 64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1);
    apply64("R5 odd seed t0", 64'h1, 64'h0, 1'b1);
    // R6: long transmit runs carrying a generate upward
    apply64("R6 ones plus one", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0);
    apply64("R6 ones plus ones", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    // R7: all half-sums one, carry-in passes to cout
    apply64("R7 propagate cin1", 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1);
    apply64("R7 propagate cin0", 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0);
    apply64("R7 slice boundary", 64'h0000_0000_0000_00FF, 64'h1, 1'b0);
    apply64("R7 ones cin", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1);
    // R8: back-to-back changes, no clock edge between input and sample
    apply64("R8 change a", 64'h0123_4567_89AB_CDEF, 64'h1111_1111_1111_1111, 1'b0);
    apply64("R8 change cin", 64'h0123_4567_89AB_CDEF, 64'h1111_1111_1111_1111, 1'b1);

    // R2: exhaustive 8-bit variant
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        for (int c = 0; c < 2; c++) begin
          a8 = i[7:0]; b8 = j[7:0]; ci8 = c[0];
          #1;
          check("R2 exhaustive 8-bit", {56'h0, co8, s8}, model_add({56'h0, a8}, {56'h0, b8}, ci8, 8));
        end
      end
    end

    // R2: 16- and 32-bit variants
    for (int n = 0; n < 300; n++) begin
      a16 = 16'($urandom); b16 = 16'($urandom); ci16 = 1'($urandom);
      a32 = $urandom;      b32 = $urandom;      ci32 = 1'($urandom);
      #1;
      check("R2 16-bit", {48'h0, co16, s16}, model_add({48'h0, a16}, {48'h0, b16}, ci16, 16));
      check("R2 32-bit", {32'h0, co32, s32}, model_add({32'h0, a32}, {32'h0, b32}, ci32, 32));
    end

    // R1: random 64-bit, half of them biased toward long propagate runs
    for (int n = 0; n < 3000; n++) begin
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      if (n[0]) y = ~x ^ (64'h1 << ($urandom % 64));
      apply64("R1 random 64-bit", x, y, 1'($urandom));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule